// File: doc/BRIEF.md
# Read Window Center Calculator

This block finishes a read-leveling pass by placing each byte lane in the middle of its passing window. For every lane, the sweep logic upstream supplies two edges of the window. The first edge is where the lane locked. The second is the first failing trial after the lock, or the last sweep point. Each edge is a coarse phase plus a fine delay. The block turns both edges into a single linear position, computes the midpoint, and splits the midpoint back into a centered phase and a centered delay. While it does this, it tracks the smallest centered phase over all lanes. The caller uses that value to choose the read-ready delay adder.

The block has two clocking ratios, selected by `half_rate_n`.

- In the 2:1 ratio (`half_rate_n` = 0), phase codes are contiguous. The linear position is `phase * MAX_DLY + delay`.
- In the 1:1 ratio (`half_rate_n` = 1), the legal phase codes are 0, 1, 4 and 5. Before the arithmetic, any phase code above 1 is lowered by 2. After the arithmetic, a resulting phase above 1 is raised by 2 again.

In both ratios the midpoint is `(end - start) / 2 + start`, using integer division. The centered phase is `midpoint / MAX_DLY` and the centered delay is `midpoint % MAX_DLY`.

A one-cycle `start` pulse captures all lane edges and the ratio bit. The block then handles one lane per clock and raises `done` for one cycle after the last lane. The block is controlled by a state machine with three states:

- `ST_IDLE`: waits; goes to `ST_SCAN` on `start`.
- `ST_SCAN`: processes lane `idx` each cycle; goes to `ST_FINISH` when the last lane has been written.
- `ST_FINISH`: drives `done`; always returns to `ST_IDLE`.

A lane whose end lies before its start is flagged as an error. Its results are forced to zero and it is left out of the minimum.

Top module: `rwc_window_center`

## Requirements
- R1: After reset, `busy` and `done` are 0, every lane result and error bit is 0, and `min_phase` equals MIN_SEED (10).
- R2: With `half_rate_n` = 0, each lane's outputs are computed as follows:
  - lin = phase*MAX_DLY + delay for each edge;
  - mid = (lin_end - lin_start)/2 + lin_start, using integer division;
  - `ctr_phase` = mid / MAX_DLY and `ctr_delay` = mid % MAX_DLY.
- R3: With `half_rate_n` = 1, start and end phases above 1 are lowered by 2 before linearising, and a centered phase above 1 is raised by 2. A valid lane therefore never reports phase 2 or 3.
- R4: A lane whose start equals its end returns exactly that phase and delay, in either ratio.
- R5: When `done` is 1, `min_phase` is the smallest `ctr_phase` over lanes without an error. The search is seeded with MIN_SEED, so if every lane has an error, `min_phase` is MIN_SEED.
- R6: A lane whose linearised end is below its linearised start has its `lane_err` bit set to 1, and its `ctr_phase` and `ctr_delay` set to 0.
- R7: Timing of a run:
  - `done` is a single-cycle pulse in the LANES+1-th cycle after the cycle in which `start` is sampled;
  - `busy` is 1 from the cycle after that start through the `done` cycle;
  - `busy` is 0 in the cycle after `done`.
- R8: `start` pulses while `busy` is 1 are ignored. Changes to the edge inputs or `half_rate_n` after the accepted start do not affect the results of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that captures the inputs and begins a run |
| half_rate_n | input | 1 | 1 selects the 1:1 ratio with phase codes 0,1,4,5; 0 selects the 2:1 ratio |
| ws_phase | input | LANES*PH_W | Window-start phase per lane, lane i at bits [i*PH_W +: PH_W] |
| ws_delay | input | LANES*DLY_W | Window-start delay per lane |
| we_phase | input | LANES*PH_W | Window-end phase per lane |
| we_delay | input | LANES*DLY_W | Window-end delay per lane |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse; results and minimum are valid |
| ctr_phase | output | LANES*PH_W | Centered phase per lane |
| ctr_delay | output | LANES*DLY_W | Centered delay per lane |
| lane_err | output | LANES | Set for a lane whose end precedes its start |
| min_phase | output | PH_W | Smallest centered phase over lanes without an error |

## Verification
The checker assumes that the upstream sweep gives phase codes 0, 1, 4 or 5 in the 1:1 ratio, and delays below MAX_DLY. Under those inputs, any valid result in that ratio stays clear of codes 2 and 3. The checker also assumes that `start` is a pulse, and it judges the phase-gap property against the ratio captured at start rather than the live pin. The bench sweeps every legal start/end pair in both ratios, including reversed pairs that must raise the error. It pulses `start` and changes the inputs only in the middle of a run, when the design is required to ignore them.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } rwc_state_e;
endpackage

// File: rtl/rwc_lane_snapshot.sv
module rwc_lane_snapshot #(
    parameter int LANES = 4,
    parameter int PH_W  = 4,
    parameter int DLY_W = 3,
    parameter int IDX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   mode_in,
    input  logic [LANES*PH_W-1:0]  s_ph_in,
    input  logic [LANES*DLY_W-1:0] s_dl_in,
    input  logic [LANES*PH_W-1:0]  e_ph_in,
    input  logic [LANES*DLY_W-1:0] e_dl_in,
    input  logic [IDX_W-1:0]       sel,
    output logic                   mode_q,
    output logic [PH_W-1:0]        s_ph,
    output logic [DLY_W-1:0]       s_dl,
    output logic [PH_W-1:0]        e_ph,
    output logic [DLY_W-1:0]       e_dl
);
    logic [LANES*PH_W-1:0]  s_ph_q, e_ph_q;
    logic [LANES*DLY_W-1:0] s_dl_q, e_dl_q;
    logic [PH_W-1:0]        s_ph_a [LANES];
    logic [PH_W-1:0]        e_ph_a [LANES];
    logic [DLY_W-1:0]       s_dl_a [LANES];
    logic [DLY_W-1:0]       e_dl_a [LANES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            s_ph_q <= '0;
            s_dl_q <= '0;
            e_ph_q <= '0;
            e_dl_q <= '0;
        end else if (load) begin
            mode_q <= mode_in;
            s_ph_q <= s_ph_in;
            s_dl_q <= s_dl_in;
            e_ph_q <= e_ph_in;
            e_dl_q <= e_dl_in;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign s_ph_a[g] = s_ph_q[g*PH_W +: PH_W];
        assign e_ph_a[g] = e_ph_q[g*PH_W +: PH_W];
        assign s_dl_a[g] = s_dl_q[g*DLY_W +: DLY_W];
        assign e_dl_a[g] = e_dl_q[g*DLY_W +: DLY_W];
    end

    assign s_ph = s_ph_a[sel];
    assign s_dl = s_dl_a[sel];
    assign e_ph = e_ph_a[sel];
    assign e_dl = e_dl_a[sel];
endmodule

// File: rtl/rwc_center_math.sv
module rwc_center_math #(
    parameter int PH_W    = 4,
    parameter int DLY_W   = 3,
    parameter int MAX_DLY = 8,
    parameter int LIN_W   = 8
) (
    input  logic             half_rate_n,
    input  logic [PH_W-1:0]  s_ph,
    input  logic [DLY_W-1:0] s_dl,
    input  logic [PH_W-1:0]  e_ph,
    input  logic [DLY_W-1:0] e_dl,
    output logic [PH_W-1:0]  c_ph,
    output logic [DLY_W-1:0] c_dl,
    output logic             bad
);
    localparam logic [LIN_W-1:0] STEP = LIN_W'(MAX_DLY);

    logic [PH_W-1:0]  s_ph_c, e_ph_c, ph_lin;
    logic [LIN_W-1:0] s_lin, e_lin, mid;

    always_comb begin
        s_ph_c = (half_rate_n && (s_ph > PH_W'(1))) ? s_ph - PH_W'(2) : s_ph;
        e_ph_c = (half_rate_n && (e_ph > PH_W'(1))) ? e_ph - PH_W'(2) : e_ph;
        s_lin  = LIN_W'(s_ph_c) * STEP + LIN_W'(s_dl);
        e_lin  = LIN_W'(e_ph_c) * STEP + LIN_W'(e_dl);
        bad    = e_lin < s_lin;
        mid    = bad ? s_lin : (((e_lin - s_lin) >> 1) + s_lin);
        ph_lin = PH_W'(mid / STEP);
        if (bad) begin
            c_ph = '0;
            c_dl = '0;
        end else begin
            c_ph = (half_rate_n && (ph_lin > PH_W'(1))) ? ph_lin + PH_W'(2) : ph_lin;
            c_dl = DLY_W'(mid % STEP);
        end
    end
endmodule

// File: rtl/rwc_result_bank.sv
module rwc_result_bank #(
    parameter int LANES = 4,
    parameter int PH_W  = 4,
    parameter int DLY_W = 3,
    parameter int IDX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [PH_W-1:0]        wr_ph,
    input  logic [DLY_W-1:0]       wr_dl,
    input  logic                   wr_bad,
    output logic [LANES*PH_W-1:0]  ph_out,
    output logic [LANES*DLY_W-1:0] dl_out,
    output logic [LANES-1:0]       err_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ph_out[g*PH_W +: PH_W]   <= '0;
                dl_out[g*DLY_W +: DLY_W] <= '0;
                err_out[g]               <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ph_out[g*PH_W +: PH_W]   <= wr_ph;
                dl_out[g*DLY_W +: DLY_W] <= wr_dl;
                err_out[g]               <= wr_bad;
            end
        end
    end
endmodule

// File: rtl/rwc_window_center.sv
module rwc_window_center #(
    parameter int LANES    = 4,
    parameter int PH_W     = 4,
    parameter int MAX_DLY  = 8,
    parameter int MIN_SEED = 10,
    localparam int DLY_W   = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1,
    localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int LIN_W   = PH_W + DLY_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   half_rate_n,
    input  logic [LANES*PH_W-1:0]  ws_phase,
    input  logic [LANES*DLY_W-1:0] ws_delay,
    input  logic [LANES*PH_W-1:0]  we_phase,
    input  logic [LANES*DLY_W-1:0] we_delay,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*PH_W-1:0]  ctr_phase,
    output logic [LANES*DLY_W-1:0] ctr_delay,
    output logic [LANES-1:0]       lane_err,
    output logic [PH_W-1:0]        min_phase
);
    import rwc_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);
    localparam logic [PH_W-1:0]  SEED     = PH_W'(MIN_SEED);

    rwc_state_e       state_q, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic             load, scan_we;
    logic             mode_q;
    logic [PH_W-1:0]  s_ph, e_ph, c_ph, min_q;
    logic [DLY_W-1:0] s_dl, e_dl, c_dl;
    logic             c_bad;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_nx = ST_SCAN;
            ST_SCAN:   if (idx_q == LAST_IDX) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        scan_we = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_SCAN:   begin busy = 1'b1; scan_we = 1'b1; end
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    // lane index and running minimum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            min_q <= SEED;
        end else begin
            if (load) begin
                idx_q <= '0;
                min_q <= SEED;
            end else if (scan_we) begin
                idx_q <= idx_q + IDX_W'(1);
                if (!c_bad && (c_ph < min_q)) min_q <= c_ph;
            end
        end
    end

    assign min_phase = min_q;

    rwc_lane_snapshot #(
        .LANES(LANES), .PH_W(PH_W), .DLY_W(DLY_W), .IDX_W(IDX_W)
    ) u_snap (
        .clk(clk), .rst_n(rst_n), .load(load), .mode_in(half_rate_n),
        .s_ph_in(ws_phase), .s_dl_in(ws_delay),
        .e_ph_in(we_phase), .e_dl_in(we_delay),
        .sel(idx_q), .mode_q(mode_q),
        .s_ph(s_ph), .s_dl(s_dl), .e_ph(e_ph), .e_dl(e_dl)
    );

    rwc_center_math #(
        .PH_W(PH_W), .DLY_W(DLY_W), .MAX_DLY(MAX_DLY), .LIN_W(LIN_W)
    ) u_math (
        .half_rate_n(mode_q), .s_ph(s_ph), .s_dl(s_dl),
        .e_ph(e_ph), .e_dl(e_dl),
        .c_ph(c_ph), .c_dl(c_dl), .bad(c_bad)
    );

    rwc_result_bank #(
        .LANES(LANES), .PH_W(PH_W), .DLY_W(DLY_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(scan_we), .wr_idx(idx_q),
        .wr_ph(c_ph), .wr_dl(c_dl), .wr_bad(c_bad),
        .ph_out(ctr_phase), .dl_out(ctr_delay), .err_out(lane_err)
    );
endmodule

// File: rtl/rwc_window_center_chk.sv
module rwc_window_center_chk #(
    parameter int LANES    = 4,
    parameter int PH_W     = 4,
    parameter int DLY_W    = 3,
    parameter int MIN_SEED = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   mode_q,
    input logic [LANES*PH_W-1:0]  ctr_phase,
    input logic [LANES*DLY_W-1:0] ctr_delay,
    input logic [LANES-1:0]       lane_err,
    input logic [PH_W-1:0]        min_phase
);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_start_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_min_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (min_phase <= PH_W'(MIN_SEED)));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (done && lane_err[g]) |->
            (ctr_phase[g*PH_W +: PH_W] == '0 && ctr_delay[g*DLY_W +: DLY_W] == '0));
        p_min_below_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !lane_err[g]) |-> (min_phase <= ctr_phase[g*PH_W +: PH_W]));
        p_phase_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (done && mode_q && !lane_err[g]) |->
            (ctr_phase[g*PH_W +: PH_W] != PH_W'(2) && ctr_phase[g*PH_W +: PH_W] != PH_W'(3)));
    end
endmodule

bind rwc_window_center rwc_window_center_chk #(
    .LANES(LANES), .PH_W(PH_W), .DLY_W(DLY_W), .MIN_SEED(MIN_SEED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mode_q(mode_q), .ctr_phase(ctr_phase), .ctr_delay(ctr_delay),
    .lane_err(lane_err), .min_phase(min_phase)
);

// File: tb/sim_rwc_window_center.sv
`timescale 1ns/1ps
module sim_rwc_window_center;
    localparam int LANES = 4;
    localparam int PH_W  = 4;
    localparam int MAXD  = 8;
    localparam int SEED  = 10;
    localparam int DLY_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic half_rate_n = 1'b0;
    logic [LANES*PH_W-1:0]  ws_phase = '0, we_phase = '0;
    logic [LANES*DLY_W-1:0] ws_delay = '0, we_delay = '0;
    logic busy, done;
    logic [LANES*PH_W-1:0]  ctr_phase;
    logic [LANES*DLY_W-1:0] ctr_delay;
    logic [LANES-1:0]       lane_err;
    logic [PH_W-1:0]        min_phase;

    always #4 clk = ~clk;

    rwc_window_center #(.LANES(LANES), .PH_W(PH_W), .MAX_DLY(MAXD), .MIN_SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .half_rate_n(half_rate_n),
        .ws_phase(ws_phase), .ws_delay(ws_delay), .we_phase(we_phase), .we_delay(we_delay),
        .busy(busy), .done(done), .ctr_phase(ctr_phase), .ctr_delay(ctr_delay),
        .lane_err(lane_err), .min_phase(min_phase)
    );

    int n_chk = 0;
    int n_bad = 0;
    int sp [LANES], sd [LANES], ep [LANES], ed [LANES];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(input bit m11, input int a_p, input int a_d,
                                  input int b_p, input int b_d,
                                  output int cp, output int cd, output bit bad);
        int ac, bc, al, bl, mid;
        ac = (m11 && a_p > 1) ? a_p - 2 : a_p;
        bc = (m11 && b_p > 1) ? b_p - 2 : b_p;
        al = ac * MAXD + a_d;
        bl = bc * MAXD + b_d;
        if (bl < al) begin
            bad = 1'b1; cp = 0; cd = 0;
        end else begin
            bad = 1'b0;
            mid = (bl - al) / 2 + al;
            cp = mid / MAXD;
            cd = mid % MAXD;
            if (m11 && cp > 1) cp = cp + 2;
        end
    endfunction

    task automatic drive_inputs(input bit m11);
        half_rate_n = m11;
        for (int i = 0; i < LANES; i++) begin
            ws_phase[i*PH_W +: PH_W]   = PH_W'(sp[i]);
            ws_delay[i*DLY_W +: DLY_W] = DLY_W'(sd[i]);
            we_phase[i*PH_W +: PH_W]   = PH_W'(ep[i]);
            we_delay[i*DLY_W +: DLY_W] = DLY_W'(ed[i]);
        end
    endtask

    // runs one job at negedge timing; disturb=1 pulses start and scrambles inputs mid-run (R8)
    task automatic run_job(input bit m11, input bit disturb, input string tag);
        int cnt, cp, cd, mn, exp_code, act_code;
        bit bad;
        drive_inputs(m11);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        if (disturb) begin
            half_rate_n = ~m11;
            ws_phase = '1; we_phase = '0; ws_delay = '1; we_delay = '0;
        end
        while (!done && cnt < 50) begin
            if (disturb && cnt == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        chk(cnt == LANES + 1, "R7 done latency", cnt, LANES + 1);
        mn = SEED;
        for (int i = 0; i < LANES; i++) begin
            model(m11, sp[i], sd[i], ep[i], ed[i], cp, cd, bad);
            if (!bad && cp < mn) mn = cp;
            exp_code = cp * 1000 + cd * 10 + int'(bad);
            act_code = int'(ctr_phase[i*PH_W +: PH_W]) * 1000 +
                       int'(ctr_delay[i*DLY_W +: DLY_W]) * 10 + int'(lane_err[i]);
            if (disturb)     chk(act_code == exp_code, "R8 lane result", act_code, exp_code);
            else if (bad)    chk(act_code == exp_code, "R6 lane error", act_code, exp_code);
            else if (m11)    chk(act_code == exp_code, {tag, " R3 lane 1:1"}, act_code, exp_code);
            else             chk(act_code == exp_code, {tag, " R2 lane 2:1"}, act_code, exp_code);
        end
        chk(int'(min_phase) == mn, "R5 min phase", int'(min_phase), mn);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R7 idle after done", int'(busy), 0);
    endtask

    function automatic int ph_code(input bit m11, input int k);
        if (m11) return (k < 2) ? k : k + 2;
        return k;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", int'(busy) + int'(done), 0);
        chk(int'(min_phase) == SEED, "R1 reset min", int'(min_phase), SEED);
        chk(ctr_phase == '0 && ctr_delay == '0 && lane_err == '0, "R1 reset results",
            int'(lane_err), 0);

        // R4 equal edges in both ratios
        sp = '{0, 1, 3, 2}; sd = '{0, 7, 5, 3};
        ep = sp; ed = sd;
        run_job(1'b0, 1'b0, "R4");
        sp = '{0, 1, 4, 5}; sd = '{7, 0, 3, 6};
        ep = sp; ed = sd;
        run_job(1'b1, 1'b0, "R4");

        // R5/R6 all lanes reversed: min stays at seed
        sp = '{3, 3, 2, 1}; sd = '{7, 1, 0, 4};
        ep = '{0, 2, 1, 1}; ed = '{0, 7, 7, 3};
        run_job(1'b0, 1'b0, "R6");

        // R8 start and input changes during a run are ignored
        sp = '{0, 1, 0, 2}; sd = '{2, 0, 5, 1};
        ep = '{2, 3, 1, 3}; ed = '{6, 4, 0, 7};
        run_job(1'b0, 1'b1, "R8");

        // exhaustive sweep of start/end pairs in both ratios
        for (int m = 0; m < 2; m++) begin
            int slot;
            slot = 0;
            for (int s = 0; s < 4 * MAXD; s++) begin
                for (int e = 0; e < 4 * MAXD; e++) begin
                    sp[slot] = ph_code(m[0], s / MAXD); sd[slot] = s % MAXD;
                    ep[slot] = ph_code(m[0], e / MAXD); ed[slot] = e % MAXD;
                    slot++;
                    if (slot == LANES) begin
                        run_job(m[0], 1'b0, "sweep");
                        slot = 0;
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule